// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

The block gathers five interrupt request lines (external line 0, timer 0, external line 1, timer 1 and the serial unit) and presents at most one of them to a processor core as a request with a 3-bit vector code. Two 8-bit configuration registers control it: a mask register and a level register. Both are written through a small register port and read back through a combinational read mux. A master bit in the mask register gates every per-source mask bit. Each source's level bit places it at the high or the low level. Within a level, a fixed order breaks ties.

The core accepts a request with `cpu_ack` and signals the end of a handler with `cpu_reti`. The controller tracks which levels are in service, so a high-level request can interrupt a running low-level handler. A low-level request can never interrupt another handler, and a request at the same level as a running handler cannot interrupt it either.

Two state machines do the work. The delivery machine has the states IDLE and REQUEST. It moves IDLE→REQUEST when an eligible candidate exists (it latches the vector and the level), REQUEST→REQUEST as an upgrade when a high candidate appears while a low request is held, REQUEST→IDLE on acknowledge, and REQUEST→IDLE on withdrawal when the master enable is off. The nesting machine has the states NONE, LOW, HIGH and BOTH. An acknowledge pushes one of these transitions: NONE→LOW, NONE→HIGH or LOW→BOTH. A return pops one: BOTH→LOW, HIGH→NONE or LOW→NONE. A return in NONE is ignored.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `cpu_req` is 0 and both registers read back as 0x00.
- R2: Register select 0 is the mask register: bits 4:0 are the per-source enables, bit 7 is the master enable, and bits 6:5 read as 0. Register select 1 is the level register: bits 4:0 are stored, bits 7:5 read as 0 and have no effect. Writes take effect at the clock edge where `reg_wr_en` is sampled high.
- R3: While mask bit 7 is 0, `cpu_req` is 0 whatever the other bits are. A request already raised is withdrawn at the second edge after the write that clears bit 7.
- R4: Source i (0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial) can request only while `irq_raw[i]` is 1 and mask bit i is 1.
- R5: Among eligible sources of one level, the lowest index wins, and `cpu_vec` carries that index.
- R6: A source whose level bit i is 1 is high-level. Any eligible high-level source wins over every low-level source, whatever their indices.
- R7: `cpu_req` rises at the first clock edge at which a candidate is present. It then stays at 1, with `cpu_vec` unchanged (except by R8), until an edge that samples `cpu_ack`. After that edge `cpu_req` is 0.
- R8: While a low-level request is held, the appearance of an eligible high-level candidate replaces the vector at the next edge, without dropping `cpu_req`.
- R9: While a low-level handler is in service, only high-level sources can request. While a high-level handler is in service, no source can request.
- R10: `cpu_reti` ends the highest level in service: from both levels it leaves low in service, and from one level it leaves none. With nothing in service it has no effect.
- R11: When `cpu_ack` and `cpu_reti` are sampled at the same edge, the return is applied first and the acknowledged level is then marked in service.
- R12: `cpu_ack` sampled while `cpu_req` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_raw | input | 5 | Raw request lines, index = source code |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 mask, 1 level |
| reg_wr_data | input | 8 | Write data |
| reg_rd_sel | input | 1 | Read target: 0 mask, 1 level |
| reg_rd_data | output | 8 | Read data, reserved bits zero |
| cpu_req | output | 1 | Interrupt request to the core |
| cpu_vec | output | 3 | Vector code of the request, 0 when idle |
| cpu_ack | input | 1 | Core accepts the current request |
| cpu_reti | input | 1 | Core finished the current handler |

## Verification
An acknowledge and a return can land on the same edge. This happens when a high-level request that preempts a low handler is accepted in the cycle in which the low handler ends. The bench provokes this by driving both strobes together while a low handler is in service and a high request is held. It judges the outcome at the ports: a low source and a high source are both kept pending afterwards, so `cpu_req` must stay 0 until a single return. If the return were applied after the acknowledge, the high source would wrongly request again. The full sweep of all 32 request patterns against all 32 level settings covers the arbitration, and a separate sweep of all per-source mask settings covers the masking.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned SRC_COUNT = 5;
    localparam int unsigned CODE_W    = 3;
    localparam int unsigned CFG_W     = 8;

    // delivery of one request to the core
    typedef enum logic {
        DLV_IDLE = 1'b0,
        DLV_REQ  = 1'b1
    } dlv_state_e;

    // which priority levels currently have a handler running
    typedef enum logic [1:0] {
        SVC_NONE = 2'd0,
        SVC_LO   = 2'd1,
        SVC_HI   = 2'd2,
        SVC_BOTH = 2'd3
    } svc_state_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int unsigned NSRC  = irq_pkg::SRC_COUNT,
    parameter int unsigned REG_W = irq_pkg::CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic [NSRC-1:0]  src_en,
    output logic [NSRC-1:0]  src_hi,
    output logic             master_en
);

    localparam int unsigned MASTER_BIT = REG_W - 1;

    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] hi_q;
    logic            master_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            hi_q     <= '0;
            master_q <= 1'b0;
        end else if (wr_en) begin
            if (!wr_sel) begin
                en_q     <= wr_data[NSRC-1:0];
                master_q <= wr_data[MASTER_BIT];
            end else begin
                hi_q     <= wr_data[NSRC-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (!rd_sel) begin
            rd_data[NSRC-1:0]  = en_q;
            rd_data[MASTER_BIT] = master_q;
        end else begin
            rd_data[NSRC-1:0]  = hi_q;
        end
    end

    assign src_en    = en_q;
    assign src_hi    = hi_q;
    assign master_en = master_q;

endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
    parameter int unsigned NSRC   = irq_pkg::SRC_COUNT,
    parameter int unsigned CODE_W = irq_pkg::CODE_W
) (
    input  logic [NSRC-1:0]   req,
    output logic              valid,
    output logic [CODE_W-1:0] idx,
    output logic [NSRC-1:0]   gnt
);

    // one-hot grant: a line wins only when every lower index is quiet
    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_gnt
            if (gi == 0) begin : g_first
                assign gnt[gi] = req[gi];
            end else begin : g_rest
                assign gnt[gi] = req[gi] & ~(|req[gi-1:0]);
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (gnt[i]) begin
                idx = CODE_W'(i);
            end
        end
    end

    assign valid = |req;

endmodule

// File: rtl/irq_nest_fsm.sv
module irq_nest_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_fire,
    input  logic ack_hi,
    input  logic reti,
    output logic lo_busy,
    output logic hi_busy
);
    import irq_pkg::*;

    svc_state_e svc_q;
    svc_state_e svc_d;
    svc_state_e popped;

    // return first, then the accepted level is pushed on top
    always_comb begin
        popped = svc_q;
        if (reti) begin
            unique case (svc_q)
                SVC_NONE: popped = SVC_NONE;
                SVC_LO:   popped = SVC_NONE;
                SVC_HI:   popped = SVC_NONE;
                SVC_BOTH: popped = SVC_LO;
                default:  popped = SVC_NONE;
            endcase
        end
        svc_d = popped;
        if (ack_fire) begin
            unique case (popped)
                SVC_NONE: svc_d = ack_hi ? SVC_HI : SVC_LO;
                SVC_LO:   svc_d = ack_hi ? SVC_BOTH : SVC_LO;
                SVC_HI:   svc_d = SVC_HI;
                SVC_BOTH: svc_d = SVC_BOTH;
                default:  svc_d = SVC_NONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc_q <= SVC_NONE;
        end else begin
            svc_q <= svc_d;
        end
    end

    always_comb begin
        lo_busy = 1'b0;
        hi_busy = 1'b0;
        unique case (svc_q)
            SVC_NONE: begin end
            SVC_LO:   lo_busy = 1'b1;
            SVC_HI:   hi_busy = 1'b1;
            SVC_BOTH: begin
                lo_busy = 1'b1;
                hi_busy = 1'b1;
            end
            default:  begin end
        endcase
    end

    // R10: a return with both levels active leaves only low in service
    p_pop_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_q == SVC_BOTH && reti && !ack_fire) |=> (lo_busy && !hi_busy));

    // R11: return plus high acknowledge from low ends in high only
    p_ack_reti_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_q == SVC_LO && reti && ack_fire && ack_hi) |=> (hi_busy && !lo_busy));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int unsigned NSRC   = irq_pkg::SRC_COUNT,
    parameter int unsigned CODE_W = irq_pkg::CODE_W,
    parameter int unsigned REG_W  = irq_pkg::CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_raw,
    input  logic              reg_wr_en,
    input  logic              reg_wr_sel,
    input  logic [REG_W-1:0]  reg_wr_data,
    input  logic              reg_rd_sel,
    output logic [REG_W-1:0]  reg_rd_data,
    output logic              cpu_req,
    output logic [CODE_W-1:0] cpu_vec,
    input  logic              cpu_ack,
    input  logic              cpu_reti
);
    import irq_pkg::*;

    localparam int unsigned NLVL = 2;

    logic [NSRC-1:0]   src_en;
    logic [NSRC-1:0]   src_hi;
    logic              master_en;
    logic [NSRC-1:0]   pend;

    logic [NSRC-1:0]   lvl_req   [NLVL];
    logic [NSRC-1:0]   lvl_gnt   [NLVL];
    logic              lvl_valid [NLVL];
    logic [CODE_W-1:0] lvl_idx   [NLVL];

    logic              lo_busy;
    logic              hi_busy;
    logic              cand_valid;
    logic              cand_hi;
    logic [CODE_W-1:0] cand_idx;

    dlv_state_e        dlv_q;
    dlv_state_e        dlv_d;
    logic [CODE_W-1:0] vec_q;
    logic [CODE_W-1:0] vec_d;
    logic              lvl_q;
    logic              lvl_d;
    logic              ack_fire;

    irq_cfg_regs #(
        .NSRC  (NSRC),
        .REG_W (REG_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_wr_sel),
        .wr_data   (reg_wr_data),
        .rd_sel    (reg_rd_sel),
        .rd_data   (reg_rd_data),
        .src_en    (src_en),
        .src_hi    (src_hi),
        .master_en (master_en)
    );

    assign pend = irq_raw & src_en & {NSRC{master_en}};

    // level 0 is low, level 1 is high
    genvar gl;
    generate
        for (gl = 0; gl < NLVL; gl++) begin : g_lvl
            if (gl == 0) begin : g_low
                assign lvl_req[gl] = pend & ~src_hi;
            end else begin : g_high
                assign lvl_req[gl] = pend & src_hi;
            end

            irq_level_pick #(
                .NSRC   (NSRC),
                .CODE_W (CODE_W)
            ) u_pick (
                .req   (lvl_req[gl]),
                .valid (lvl_valid[gl]),
                .idx   (lvl_idx[gl]),
                .gnt   (lvl_gnt[gl])
            );

            // R5: at most one granted line per level, and only a requesting one
            p_gnt_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(lvl_gnt[gl]) && ((lvl_gnt[gl] & ~lvl_req[gl]) == '0));
        end
    endgenerate

    irq_nest_fsm u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_fire (ack_fire),
        .ack_hi   (lvl_q),
        .reti     (cpu_reti),
        .lo_busy  (lo_busy),
        .hi_busy  (hi_busy)
    );

    // eligible candidate given what is already in service
    always_comb begin
        cand_valid = 1'b0;
        cand_hi    = 1'b0;
        cand_idx   = '0;
        if (lvl_valid[1] && !hi_busy) begin
            cand_valid = 1'b1;
            cand_hi    = 1'b1;
            cand_idx   = lvl_idx[1];
        end else if (lvl_valid[0] && !hi_busy && !lo_busy) begin
            cand_valid = 1'b1;
            cand_idx   = lvl_idx[0];
        end
    end

    assign ack_fire = (dlv_q == DLV_REQ) && cpu_ack;

    // delivery next-state and latch
    always_comb begin
        dlv_d = dlv_q;
        vec_d = vec_q;
        lvl_d = lvl_q;
        unique case (dlv_q)
            DLV_IDLE: begin
                if (cand_valid) begin
                    dlv_d = DLV_REQ;
                    vec_d = cand_idx;
                    lvl_d = cand_hi;
                end
            end
            DLV_REQ: begin
                if (cpu_ack) begin
                    dlv_d = DLV_IDLE;
                end else if (!master_en) begin
                    dlv_d = DLV_IDLE;
                end else if (cand_valid && cand_hi && !lvl_q) begin
                    vec_d = cand_idx;
                    lvl_d = 1'b1;
                end
            end
            default: dlv_d = DLV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dlv_q <= DLV_IDLE;
            vec_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            dlv_q <= dlv_d;
            vec_q <= vec_d;
            lvl_q <= lvl_d;
        end
    end

    always_comb begin
        cpu_req = 1'b0;
        cpu_vec = '0;
        unique case (dlv_q)
            DLV_IDLE: begin end
            DLV_REQ: begin
                cpu_req = 1'b1;
                cpu_vec = vec_q;
            end
            default: begin end
        endcase
    end

    // R3: master enable off means no request after the next edge
    p_master_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !cpu_req);

    // R7: an unacknowledged request stays up
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ack && master_en) |=> cpu_req);

    // R7: a held high-level request keeps its vector
    p_vec_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ack && master_en && lvl_q) |=> $stable(cpu_vec));

    // R9: nothing is requested while a high handler runs
    p_hi_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hi_busy |-> !cpu_req);

    // R12: a stray acknowledge leaves the service state alone
    p_ack_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_req && cpu_ack && !cpu_reti) |=> $stable({lo_busy, hi_busy}));

endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;

    localparam int NSRC = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] irq_raw = '0;
    logic       reg_wr_en = 1'b0;
    logic       reg_wr_sel = 1'b0;
    logic [7:0] reg_wr_data = '0;
    logic       reg_rd_sel = 1'b0;
    logic [7:0] reg_rd_data;
    logic       cpu_req;
    logic [2:0] cpu_vec;
    logic       cpu_ack = 1'b0;
    logic       cpu_reti = 1'b0;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_raw     (irq_raw),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_sel  (reg_wr_sel),
        .reg_wr_data (reg_wr_data),
        .reg_rd_sel  (reg_rd_sel),
        .reg_rd_data (reg_rd_data),
        .cpu_req     (cpu_req),
        .cpu_vec     (cpu_vec),
        .cpu_ack     (cpu_ack),
        .cpu_reti    (cpu_reti)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] outv();
        return {4'b0, cpu_req, cpu_vec};
    endfunction

    // expected {req,vec} with nothing in service
    function automatic logic [7:0] model(input logic [4:0] raw, input logic [4:0] en,
                                         input logic [4:0] hi);
        logic [4:0] p;
        logic [4:0] h;
        p = raw & en;
        h = p & hi;
        if (h != 0) p = h;
        for (int i = 0; i < NSRC; i++) begin
            if (p[i]) return 8'(8 + i);
        end
        return 8'h00;
    endfunction

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr_en   = 1'b1;
        reg_wr_sel  = sel;
        reg_wr_data = d;
        tick();
        reg_wr_en   = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        reg_rd_sel = sel;
        #1;
        d = reg_rd_data;
    endtask

    // accept whatever is requested, drop the lines, then end the handler
    task automatic drain();
        cpu_ack = 1'b1;
        irq_raw = '0;
        tick();
        cpu_ack = 1'b0;
        chk("R7 req drops after ack", outv(), 8'h00);
        cpu_reti = 1'b1;
        tick();
        cpu_reti = 1'b0;
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        tick();
        tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 req after reset", outv(), 8'h00);
        rd(1'b0, d);
        chk("R1 mask reg after reset", d, 8'h00);
        rd(1'b1, d);
        chk("R1 level reg after reset", d, 8'h00);

        // R2 readback and reserved bits
        wr(1'b0, 8'hFF);
        rd(1'b0, d);
        chk("R2 mask readback", d, 8'h9F);
        wr(1'b1, 8'hFF);
        rd(1'b1, d);
        chk("R2 level readback", d, 8'h1F);
        wr(1'b1, 8'hE0);
        rd(1'b1, d);
        chk("R2 level reserved zero", d, 8'h00);
        irq_raw = 5'b00011;
        tick();
        chk("R2 reserved level bits ignored", outv(), 8'h08);
        drain();

        // R3 master enable
        wr(1'b0, 8'h1F);
        irq_raw = 5'b00001;
        tick();
        tick();
        chk("R3 no req with master off", outv(), 8'h00);
        wr(1'b0, 8'h9F);
        tick();
        chk("R3 req with master on", outv(), 8'h08);
        wr(1'b0, 8'h1F);
        tick();
        chk("R3 req withdrawn", outv(), 8'h00);
        irq_raw = '0;
        tick();

        // R4 sweep of per-source masks, all lines raised
        for (int e = 0; e < 32; e++) begin
            wr(1'b0, 8'(8'h80 | e));
            irq_raw = 5'h1F;
            tick();
            chk("R4 mask sweep", outv(), model(5'h1F, 5'(e), 5'h00));
            drain();
        end

        // R5 R6 sweep of all request patterns against all level settings
        wr(1'b0, 8'h9F);
        for (int h = 0; h < 32; h++) begin
            wr(1'b1, 8'(h));
            for (int r = 0; r < 32; r++) begin
                irq_raw = 5'(r);
                tick();
                chk("R5 R6 arbitration sweep", outv(), model(5'(r), 5'h1F, 5'(h)));
                drain();
            end
        end

        // R7 hold until ack, R8 upgrade: timer 1 high, serial low
        wr(1'b1, 8'h08);
        irq_raw = 5'b10000;
        tick();
        chk("R7 low request raised", outv(), 8'h0C);
        irq_raw = 5'b00000;
        tick();
        chk("R7 request held without line", outv(), 8'h0C);
        irq_raw = 5'b01000;
        tick();
        chk("R8 upgraded to high vector", outv(), 8'h0B);
        drain();

        // R9 R10 nesting: timer 0 high, external 0 low
        wr(1'b1, 8'h02);
        irq_raw = 5'b00001;
        tick();
        chk("R9 low request", outv(), 8'h08);
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        tick();
        chk("R9 low blocked by low in service", outv(), 8'h00);
        irq_raw = 5'b00011;
        tick();
        chk("R9 high preempts low", outv(), 8'h09);
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        tick();
        chk("R9 all blocked by high in service", outv(), 8'h00);
        irq_raw = 5'b00001;
        cpu_reti = 1'b1;
        tick();
        cpu_reti = 1'b0;
        tick();
        chk("R10 low still in service after one return", outv(), 8'h00);
        cpu_reti = 1'b1;
        tick();
        cpu_reti = 1'b0;
        chk("R10 no req in return cycle", outv(), 8'h00);
        tick();
        chk("R10 low requests after second return", outv(), 8'h08);
        irq_raw = '0;
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        cpu_reti = 1'b1;
        tick();
        cpu_reti = 1'b1;
        tick();
        cpu_reti = 1'b0;
        irq_raw = 5'b00001;
        tick();
        chk("R10 extra return ignored", outv(), 8'h08);

        // R11 ack and return together: low in service, high held
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        irq_raw = 5'b00011;
        tick();
        chk("R11 high held over low", outv(), 8'h09);
        cpu_ack = 1'b1;
        cpu_reti = 1'b1;
        tick();
        cpu_ack = 1'b0;
        cpu_reti = 1'b0;
        tick();
        chk("R11 only high in service", outv(), 8'h00);
        tick();
        chk("R11 still blocked", outv(), 8'h00);
        cpu_reti = 1'b1;
        tick();
        cpu_reti = 1'b0;
        tick();
        chk("R11 high requests after return", outv(), 8'h09);
        drain();

        // R12 stray ack: nothing must become in service
        irq_raw = '0;
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        irq_raw = 5'b00001;
        tick();
        chk("R12 stray ack ignored", outv(), 8'h08);
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule